// File: doc/BRIEF.md
# Fast Link Pulse Burst Decoder with Page Matcher

This block receives link pulses that an upstream stage has already reduced to single-cycle strobes. It rebuilds the 16-bit code word carried by each burst. Within a burst, a pulse that always appears at the regular slot is a clock pulse. A pulse that may or may not appear halfway between two clock pulses carries one data bit. The block measures the spacing between pulses in clock cycles and sorts each pulse into one of three kinds: clock, data, or noise. It shifts the data bits into a word, least significant bit first.

A burst ends when the line stays quiet for a timeout that is much longer than a clock spacing. At that point the decoder does one of two things. If the burst was well formed, it presents the word with a one-cycle valid strobe. Otherwise it raises a one-cycle error strobe. A page matcher watches the stream of decoded words. It raises a matched flag once three identical words have arrived in a row, which is the condition for negotiation to move on.

All timing windows are parameters counted in clock cycles. A system integrator scales them to the real pulse spacing. The defaults are small so that simulations stay short.

Top module: `flp_rx_decoder`

## Requirements
- R1: After reset, `word_o` is 0 and `word_valid_o`, `burst_err_o` and `matched_o` are all low.
- R2: The bits of a burst are recovered from its data slots. A pulse that falls DATA_LO..DATA_HI cycles after the last clock pulse (before the next clock) means 1, and an empty slot means 0. The first bit received lands in `word_o[0]`.
- R3: After the last clock pulse of a burst holding exactly WORD_BITS bits, `word_valid_o` pulses high for one cycle, appearing END_GAP clock edges after the edge that sampled that clock pulse.
- R4: A burst that ends with fewer than or more than WORD_BITS bits, or with a data pulse that no clock pulse follows, gives a one-cycle `burst_err_o` and no valid strobe.
- R5: A pulse that arrives fewer than MIN_GAP cycles after the previous pulse of a burst causes `burst_err_o`.
- R6: A pulse whose distance from the last clock pulse falls outside both the data window and the clock window (CLK_LO..CLK_HI) causes `burst_err_o`.
- R7: After an error, pulses are ignored until the line has been quiet for END_GAP cycles. The next burst after that decodes normally.
- R8: `matched_o` rises together with the valid strobe of the third identical consecutive word. It stays high while further identical words arrive.
- R9: A valid word that differs from the previous one clears `matched_o`. Two more copies of the new word are then needed to set it again.
- R10: A malformed burst clears `matched_o` and resets the run of identical words to zero.
- R11: `word_valid_o` and `burst_err_o` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_i | input | 1 | Conditioned link pulse strobe, one cycle per pulse |
| word_o | output | WORD_BITS | Last decoded code word |
| word_valid_o | output | 1 | One-cycle strobe when `word_o` is updated |
| matched_o | output | 1 | Three identical consecutive words received |
| burst_err_o | output | 1 | One-cycle strobe for a malformed burst |

## Verification
The bench covers several corner cases, each chosen because a specific design mistake would show up there.

- **Window edges.** A decoder with the wrong window limits would either call a clock pulse a data pulse or accept a pulse that falls between the windows. The bench sends a pulse in that gap, and a pulse squeezed inside the minimum spacing.
- **Burst length.** A decoder that miscounts bits would emit a word for a 15-bit or 17-bit burst. So would one that forgets a pending data pulse when the burst ends.
- **Matcher run.** The bench replays identical, differing and broken bursts in sequence. A matcher that does not restart its run on a new word would assert matched too early. One that ignores broken bursts would keep matched set after one.
- **Recovery and timing.** The bench sends pulses while the decoder is recovering from an error, and checks the exact cycle of the valid strobe. A decoder that leaves recovery too early, or that mis-times its timeout, fails these checks.

// File: rtl/flp_pkg.sv
package flp_pkg;

  typedef enum logic [1:0] {
    DS_IDLE    = 2'd0,
    DS_BURST   = 2'd1,
    DS_RECOVER = 2'd2
  } dec_state_e;

  // true when a gap (cycles) lies inside the closed window [lo, hi]
  function automatic logic gap_in(input int unsigned gap,
                                  input int unsigned lo,
                                  input int unsigned hi);
    return (gap >= lo) && (gap <= hi);
  endfunction

  // length of the run of identical words after one more valid word
  function automatic int unsigned next_run(input int unsigned cur,
                                           input logic same,
                                           input int unsigned cap);
    if (!same) return 1;
    if (cur >= cap) return cap;
    return cur + 1;
  endfunction

endpackage

// File: rtl/flp_gap_timer.sv
module flp_gap_timer #(
  parameter int unsigned CAP = 80,
  localparam int unsigned CW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] gap
);

  // gap reads N in the cycle that lies N edges after the restart edge
  always_ff @(posedge clk) begin
    if (!rst_n)            gap <= CW'(CAP);
    else if (restart)      gap <= CW'(1);
    else if (gap != CW'(CAP)) gap <= gap + CW'(1);
  end

  a_r3_restart_loads_one: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (gap == CW'(1)));

  a_r3_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(gap) <= CAP);

endmodule

// File: rtl/flp_burst_decoder.sv
module flp_burst_decoder
  import flp_pkg::*;
#(
  parameter int unsigned WORD_BITS = 16,
  parameter int unsigned MIN_GAP   = 8,
  parameter int unsigned DATA_LO   = 14,
  parameter int unsigned DATA_HI   = 26,
  parameter int unsigned CLK_LO    = 34,
  parameter int unsigned CLK_HI    = 46,
  parameter int unsigned END_GAP   = 80,
  localparam int unsigned CW  = $clog2(END_GAP + 1),
  localparam int unsigned NBW = $clog2(WORD_BITS + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pulse_i,
  input  logic [CW-1:0]        since_clk,
  input  logic [CW-1:0]        since_pulse,
  output logic                 clk_evt,
  output logic                 done_evt,
  output logic                 err_evt,
  output logic [WORD_BITS-1:0] word_next,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o,
  output logic                 err_o
);

  localparam logic [NBW-1:0] NB_FULL = NBW'(WORD_BITS);
  localparam logic [NBW-1:0] NB_OVER = NBW'(WORD_BITS + 1);

  dec_state_e           st, st_n;
  logic [WORD_BITS-1:0] sh, sh_n;
  logic [NBW-1:0]       nb, nb_n;
  logic                 dp, dp_n;

  // named pulse classifications, used by the FSM and the assertions
  logic too_close, in_data, in_clock, quiet_clk, quiet_any;
  assign too_close = 32'(since_pulse) < MIN_GAP;
  assign in_data   = gap_in(32'(since_clk), DATA_LO, DATA_HI);
  assign in_clock  = gap_in(32'(since_clk), CLK_LO, CLK_HI);
  assign quiet_clk = 32'(since_clk) >= END_GAP;
  assign quiet_any = 32'(since_pulse) >= END_GAP;

  always_comb begin
    st_n     = st;
    sh_n     = sh;
    nb_n     = nb;
    dp_n     = dp;
    clk_evt  = 1'b0;
    done_evt = 1'b0;
    err_evt  = 1'b0;
    unique case (st)
      DS_IDLE: begin
        if (pulse_i) begin
          st_n    = DS_BURST;
          clk_evt = 1'b1;
          sh_n    = '0;
          nb_n    = '0;
          dp_n    = 1'b0;
        end
      end
      DS_BURST: begin
        if (pulse_i) begin
          if (too_close) begin
            err_evt = 1'b1;
            st_n    = DS_RECOVER;
          end else if (!dp && in_data) begin
            dp_n = 1'b1;
          end else if (in_clock) begin
            clk_evt = 1'b1;
            sh_n    = {dp, sh[WORD_BITS-1:1]};
            dp_n    = 1'b0;
            if (nb != NB_OVER) nb_n = nb + NBW'(1);
          end else begin
            err_evt = 1'b1;
            st_n    = DS_RECOVER;
          end
        end else if (quiet_clk) begin
          st_n = DS_IDLE;
          if (nb == NB_FULL && !dp) done_evt = 1'b1;
          else                      err_evt  = 1'b1;
        end
      end
      DS_RECOVER: begin
        if (!pulse_i && quiet_any) st_n = DS_IDLE;
      end
      default: st_n = DS_IDLE;
    endcase
  end

  assign word_next = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= DS_IDLE;
      sh      <= '0;
      nb      <= '0;
      dp      <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      st      <= st_n;
      sh      <= sh_n;
      nb      <= nb_n;
      dp      <= dp_n;
      valid_o <= done_evt;
      err_o   <= err_evt;
      if (done_evt) word_o <= sh;
    end
  end

  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));

  a_r11_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  a_r3_valid_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (32'(since_clk) >= END_GAP));

  a_r7_recover_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DS_RECOVER) |=> !valid_o);

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    nb <= NB_OVER);

endmodule

// File: rtl/flp_page_matcher.sv
module flp_page_matcher
  import flp_pkg::*;
#(
  parameter int unsigned WORD_BITS = 16,
  parameter int unsigned MATCH_N   = 3,
  localparam int unsigned RW = $clog2(MATCH_N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_evt,
  input  logic                 err_evt,
  input  logic [WORD_BITS-1:0] word_in,
  output logic                 matched_o
);

  logic [RW-1:0]        run;
  logic [WORD_BITS-1:0] last_word;
  logic                 same_word;

  assign same_word = (run != '0) && (word_in == last_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run       <= '0;
      last_word <= '0;
    end else if (err_evt) begin
      run <= '0;
    end else if (done_evt) begin
      run       <= RW'(next_run(32'(run), same_word, MATCH_N));
      last_word <= word_in;
    end
  end

  assign matched_o = (run == RW'(MATCH_N));

  a_r10_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !matched_o);

  a_r9_new_word_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !same_word && MATCH_N > 1) |=> !matched_o);

  a_r8_rise_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched_o) |-> $past(done_evt));

  a_r8_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(run) <= MATCH_N);

endmodule

// File: rtl/flp_rx_decoder.sv
module flp_rx_decoder #(
  parameter int unsigned WORD_BITS = 16,
  parameter int unsigned MIN_GAP   = 8,
  parameter int unsigned DATA_LO   = 14,
  parameter int unsigned DATA_HI   = 26,
  parameter int unsigned CLK_LO    = 34,
  parameter int unsigned CLK_HI    = 46,
  parameter int unsigned END_GAP   = 80,
  parameter int unsigned MATCH_N   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pulse_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 word_valid_o,
  output logic                 matched_o,
  output logic                 burst_err_o
);

  localparam int unsigned CW = $clog2(END_GAP + 1);

  logic [CW-1:0]        since_clk, since_pulse;
  logic                 clk_evt, done_evt, err_evt;
  logic [WORD_BITS-1:0] word_next;

  flp_gap_timer #(.CAP(END_GAP)) u_clk_gap (
    .clk(clk), .rst_n(rst_n), .restart(clk_evt), .gap(since_clk)
  );

  flp_gap_timer #(.CAP(END_GAP)) u_pulse_gap (
    .clk(clk), .rst_n(rst_n), .restart(pulse_i), .gap(since_pulse)
  );

  flp_burst_decoder #(
    .WORD_BITS(WORD_BITS), .MIN_GAP(MIN_GAP),
    .DATA_LO(DATA_LO), .DATA_HI(DATA_HI),
    .CLK_LO(CLK_LO), .CLK_HI(CLK_HI), .END_GAP(END_GAP)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i),
    .since_clk(since_clk), .since_pulse(since_pulse),
    .clk_evt(clk_evt), .done_evt(done_evt), .err_evt(err_evt),
    .word_next(word_next), .word_o(word_o),
    .valid_o(word_valid_o), .err_o(burst_err_o)
  );

  flp_page_matcher #(.WORD_BITS(WORD_BITS), .MATCH_N(MATCH_N)) u_match (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .err_evt(err_evt),
    .word_in(word_next), .matched_o(matched_o)
  );

  a_r8_match_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(matched_o) |-> word_valid_o);

  a_r10_err_drops_match: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err_o |-> !matched_o);

endmodule

// File: tb/tb_flp_rx_decoder.sv
module tb_flp_rx_decoder;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pulse_i = 1'b0;
  logic [W-1:0] word_o;
  logic         word_valid_o, matched_o, burst_err_o;

  always #2.5 clk = ~clk;

  flp_rx_decoder dut (
    .clk(clk), .rst_n(rst_n), .pulse_i(pulse_i),
    .word_o(word_o), .word_valid_o(word_valid_o),
    .matched_o(matched_o), .burst_err_o(burst_err_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // strobe monitor
  int           n_valid = 0, n_err = 0, n_bad_strobe = 0;
  logic [W-1:0] seen_word = '0;
  logic         prev_v = 1'b0, prev_e = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid_o) begin n_valid++; seen_word = word_o; end
      if (burst_err_o) n_err++;
      if ((word_valid_o && burst_err_o) || (word_valid_o && prev_v) ||
          (burst_err_o && prev_e)) n_bad_strobe++;
    end
    prev_v = word_valid_o;
    prev_e = burst_err_o;
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one pulse strobe; called and returns at a falling edge
  task automatic fire();
    pulse_i = 1'b1;
    @(negedge clk);
    pulse_i = 1'b0;
  endtask

  // clock pulses 40 cycles apart, data pulses halfway
  task automatic burst_body(input logic [W-1:0] w, input int nbits, input bit dangle);
    fire();
    for (int i = 0; i < nbits; i++) begin
      if (w[i % W]) begin idle(19); fire(); idle(19); end
      else idle(39);
      fire();
    end
    if (dangle) begin idle(19); fire(); end
  endtask

  // vectors: {nbits[4:0], word[15:0]}
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {5'd16, 16'hA5C3}, {5'd16, 16'hA5C3}, {5'd16, 16'hA5C3}, {5'd16, 16'hA5C3},
    {5'd16, 16'h0001}, {5'd16, 16'h0001}, {5'd16, 16'h0001}, {5'd15, 16'h0001},
    {5'd16, 16'h0001}, {5'd16, 16'hFFFF}, {5'd16, 16'h0000}, {5'd17, 16'h8000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int           run = 0;
    logic [W-1:0] prev = '0;
    int           v0, e0;

    idle(5);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1", 32'(word_o), 32'h0, "word after reset");
    check("R1", {29'b0, word_valid_o, burst_err_o, matched_o}, 32'h0, "strobes after reset");

    // table walk: R2, R3, R4, R8, R9, R10
    for (int k = 0; k < NV; k++) begin
      logic [W-1:0] w;
      int           nb;
      bit           good;
      w  = VEC[k][15:0];
      nb = int'(VEC[k][20:16]);
      good = (nb == W);
      v0 = n_valid; e0 = n_err;
      burst_body(w, nb, 1'b0);
      idle(140);
      if (good) begin
        run = (run > 0 && w == prev) ? ((run >= 3) ? 3 : run + 1) : 1;
        prev = w;
      end else run = 0;
      check(good ? "R3" : "R4", 32'(n_valid - v0), good ? 32'd1 : 32'd0, "valid strobes");
      check(good ? "R3" : "R4", 32'(n_err - e0), good ? 32'd0 : 32'd1, "error strobes");
      if (good) check("R2", 32'(seen_word), 32'(w), "decoded word");
      check(good ? "R8_R9" : "R10", 32'(matched_o), (run == 3) ? 32'd1 : 32'd0, "matched flag");
    end

    // R3 exact cycle of the valid strobe
    burst_body(16'h1234, 16, 1'b0);
    idle(79);
    check("R3", 32'(word_valid_o), 32'd0, "valid one cycle early");
    idle(1);
    check("R3", 32'(word_valid_o), 32'd1, "valid on time");
    check("R2", 32'(word_o), 32'h1234, "timed word");
    idle(60);

    // R4 dangling data pulse after the last clock
    v0 = n_valid; e0 = n_err;
    burst_body(16'h00FF, 16, 1'b1);
    idle(140);
    check("R4", 32'(n_err - e0), 32'd1, "dangling data error");
    check("R4", 32'(n_valid - v0), 32'd0, "dangling data no word");

    // R5 noise: pulse 3 cycles after a data pulse
    e0 = n_err;
    fire(); idle(19); fire(); idle(2); fire();
    idle(140);
    check("R5", 32'(n_err - e0), 32'd1, "noise pulse error");

    // R6 pulse between the data and clock windows, then R7 recovery
    v0 = n_valid; e0 = n_err;
    fire(); idle(29); fire();
    for (int j = 0; j < 3; j++) begin idle(39); fire(); end
    idle(140);
    check("R6", 32'(n_err - e0), 32'd1, "out of window error");
    check("R7", 32'(n_valid - v0), 32'd0, "pulses ignored while recovering");
    check("R10", 32'(matched_o), 32'd0, "matched after error");
    burst_body(16'hBEEF, 16, 1'b0);
    idle(140);
    check("R7", 32'(n_valid - v0), 32'd1, "burst after recovery");
    check("R7", 32'(seen_word), 32'hBEEF, "word after recovery");

    check("R11", 32'(n_bad_strobe), 32'd0, "strobe overlap or repeat");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule